// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block turns a serial receive line into parallel characters. A baud divider makes a tick at sixteen times the bit rate. The incoming line is synchronized and watched for a falling edge. A start bit is accepted only if the line is still low at its middle. After that, each data bit, the optional parity bit and the stop bits are sampled at their midpoints. The data bits are shifted in least significant bit first.

A finished character moves from the shift register into a holding register that the host reads through a one-cycle read strobe. The shift register is then free for the next character, so the host has a full character time to collect the previous one. The frame format takes eight combinations: 7 or 8 data bits, parity off or on, and 1 or 2 stop bits. When parity is on, a separate input picks even or odd parity.

The buffer-full flag, the three error flags (overrun, parity, framing) and the receive interrupt all update in the same clock cycle, at the middle of the first stop bit. They do not wait for the end of the frame. The error flags are sticky. A read of the buffer or a clear strobe removes them.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After a synchronous reset, `buf_full`, `err_overrun`, `err_parity`, `err_frame` and `rx_irq` are 0, and `rx_data` is 0x00.
- R2: A low level on the line starts a frame only if the line is still low at the middle of the start bit (8 ticks later). A shorter low pulse is a false start. It loads nothing, raises no interrupt, and leaves the receiver idle and ready for the next real frame.
- R3: Data bits are taken least significant bit first. With `fmt_len8`=1, eight bits fill `rx_data[7:0]`. With `fmt_len8`=0, seven bits fill `rx_data[6:0]` and `rx_data[7]` reads 0.
- R4: When `fmt_par_en`=1, one parity bit follows the data. With `fmt_par_odd`=0, the data bits plus the parity bit must hold an even number of ones; with `fmt_par_odd`=1, an odd number. A mismatch sets `err_parity` when the character is loaded.
- R5: If the first stop bit is sampled low, `err_frame` is set when the character is loaded.
- R6: The character, `buf_full` and the parity and framing flags are loaded at the middle of the first stop bit. This happens before a second stop bit (`fmt_stop2`=1) has been sent.
- R7: `rx_irq` is a one-cycle pulse in the cycle a character is loaded. It is high whenever `buf_full` changes from 0 to 1.
- R8: A one-cycle `rd_strobe` clears `buf_full` and all three error flags. `rx_data` keeps its value.
- R9: If a character completes while `buf_full`=1 and no `rd_strobe` comes in the same cycle, the character is discarded and `err_overrun` is set. `rx_data` and `buf_full` keep their values.
- R10: A one-cycle `err_clr` clears all three error flags and leaves `buf_full` and `rx_data` unchanged.
- R11: While the next character is being shifted in, the buffer keeps the previous character. If the buffer is read during that time, the new character loads with no overrun.
- R12: One bit lasts 16 × (`baud_div` + 1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd_in | input | 1 | Serial receive line; idles high |
| baud_div | input | DIV_W | A 16x tick occurs every baud_div+1 cycles |
| fmt_len8 | input | 1 | 1: eight data bits, 0: seven |
| fmt_par_en | input | 1 | 1: a parity bit follows the data |
| fmt_par_odd | input | 1 | 1: odd parity, 0: even parity |
| fmt_stop2 | input | 1 | 1: two stop bits, 0: one |
| rd_strobe | input | 1 | One-cycle read of the receive buffer |
| err_clr | input | 1 | One-cycle clear of the error flags |
| rx_data | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Buffer holds an unread character |
| err_overrun | output | 1 | A character was lost because the buffer was full |
| err_parity | output | 1 | Parity mismatch on the buffered character |
| err_frame | output | 1 | First stop bit was low on the buffered character |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench watches `buf_full` twice during the first stop bit of a two-stop frame: early in the bit it must still be 0, late in the bit it must be 1. A receiver that loads at the end of the frame fails the second check, and one that loads a bit too early fails the first.

A short low glitch is sent before a real frame. A receiver without mid-bit confirmation would capture a bogus character or fall out of step with the real frame.

The buffer is read in the middle of the next character's data bits. A single-buffered design would lose the character or report a false overrun.

An unread buffer is then hit by a second character. The bench checks that the old data survives and that only `err_overrun` rises. Odd and even parity, seven-bit frames and two divider settings catch wrong parity sense, a stray top bit and an off-by-one bit period.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int OSR      = 16;
  localparam int MAX_BITS = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                par_err;
    logic                frm_err;
  } rx_char_t;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R12: a tick is followed by a full count before the next one when div > 0
  a_r12_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rxd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rxd_s,
  input  logic     len8,
  input  logic     par_en,
  input  logic     par_odd,
  input  logic     stop2,
  output logic     done,
  output rx_char_t chr
);
  localparam int OSR_W = $clog2(OSR);
  localparam int IDX_W = $clog2(MAX_BITS);
  localparam logic [OSR_W-1:0] HALF_LAST = OSR_W'(OSR/2 - 1);
  localparam logic [OSR_W-1:0] FULL_LAST = OSR_W'(OSR - 1);

  rx_state_e           state;
  logic [OSR_W-1:0]    ocnt;
  logic [IDX_W-1:0]    bidx;
  logic [MAX_BITS-1:0] shreg;
  logic                par_acc;
  logic [IDX_W-1:0]    last_idx;
  logic                at_mid;

  assign last_idx = len8 ? IDX_W'(MAX_BITS-1) : IDX_W'(MAX_BITS-2);
  assign at_mid   = (ocnt == FULL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      ocnt    <= '0;
      bidx    <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      done    <= 1'b0;
      chr     <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            ocnt <= '0;
            if (!rxd_s) state <= RX_START;
          end
          RX_START: begin
            if (ocnt == HALF_LAST) begin
              ocnt <= '0;
              if (rxd_s) begin
                state <= RX_IDLE;
              end else begin
                state   <= RX_DATA;
                bidx    <= '0;
                shreg   <= '0;
                par_acc <= 1'b0;
              end
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          RX_DATA: begin
            ocnt <= ocnt + 1'b1;
            if (at_mid) begin
              shreg[bidx] <= rxd_s;
              par_acc     <= par_acc ^ rxd_s;
              if (bidx == last_idx) state <= par_en ? RX_PAR : RX_STOP1;
              else                  bidx  <= bidx + 1'b1;
            end
          end
          RX_PAR: begin
            ocnt <= ocnt + 1'b1;
            if (at_mid) begin
              par_acc <= par_acc ^ rxd_s;
              state   <= RX_STOP1;
            end
          end
          RX_STOP1: begin
            ocnt <= ocnt + 1'b1;
            if (at_mid) begin
              done        <= 1'b1;
              chr.data    <= shreg;
              chr.par_err <= par_en & (par_acc ^ par_odd);
              chr.frm_err <= ~rxd_s;
              state       <= stop2 ? RX_STOP2 : RX_IDLE;
            end
          end
          RX_STOP2: begin
            ocnt <= ocnt + 1'b1;
            if (at_mid) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R2: a high line seen while idle never starts a frame
  a_r2_idle_on_high: assert property (@(posedge clk) disable iff (rst)
    (state == RX_IDLE && tick && rxd_s) |=> state == RX_IDLE);

  // R2: a start bit that is high at mid-bit returns to idle
  a_r2_false_start: assert property (@(posedge clk) disable iff (rst)
    (state == RX_START && tick && ocnt == HALF_LAST && rxd_s) |=> state == RX_IDLE);

  // R6: a character completes only from the first stop bit
  a_r6_done_from_stop1: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(state) == RX_STOP1);
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
  import rxd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                done,
  input  rx_char_t            chr,
  input  logic                rd_strobe,
  input  logic                err_clr,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                buf_full,
  output logic                err_overrun,
  output logic                err_parity,
  output logic                err_frame,
  output logic                rx_irq
);
  logic accept;

  assign accept = done && (!buf_full || rd_strobe);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      buf_full    <= 1'b0;
      err_overrun <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      rx_irq      <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (accept) begin
        rx_data     <= chr.data;
        buf_full    <= 1'b1;
        err_parity  <= chr.par_err;
        err_frame   <= chr.frm_err;
        err_overrun <= 1'b0;
        rx_irq      <= 1'b1;
      end else begin
        if (rd_strobe || err_clr) begin
          err_overrun <= 1'b0;
          err_parity  <= 1'b0;
          err_frame   <= 1'b0;
        end
        if (rd_strobe) buf_full <= 1'b0;
        if (done)      err_overrun <= 1'b1;
      end
    end
  end

  // R7: interrupt only with a full buffer
  a_r7_irq_needs_full: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> buf_full);

  // R7: every rise of the full flag comes with an interrupt
  a_r7_rise_gives_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_full) |-> rx_irq);

  // R8: a read with no completing character empties the buffer
  a_r8_read_empties: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !done) |=> !buf_full);

  // R9: overrun only rises on an already full buffer
  a_r9_ovr_needs_full: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overrun) |-> $past(buf_full));

  // R9: a discarded character leaves the buffer contents alone
  a_r9_ovr_keeps_data: assert property (@(posedge clk) disable iff (rst)
    (done && buf_full && !rd_strobe) |=> $stable(rx_data));
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
  import rxd_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd_in,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             fmt_len8,
  input  logic             fmt_par_en,
  input  logic             fmt_par_odd,
  input  logic             fmt_stop2,
  input  logic             rd_strobe,
  input  logic             err_clr,
  output logic [7:0]       rx_data,
  output logic             buf_full,
  output logic             err_overrun,
  output logic             err_parity,
  output logic             err_frame,
  output logic             rx_irq
);
  logic     tick;
  logic     rxd_s;
  logic     done;
  rx_char_t chr;

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .div  (baud_div),
    .tick (tick)
  );

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd_in),
    .dout (rxd_s)
  );

  rx_frame u_frame (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .rxd_s   (rxd_s),
    .len8    (fmt_len8),
    .par_en  (fmt_par_en),
    .par_odd (fmt_par_odd),
    .stop2   (fmt_stop2),
    .done    (done),
    .chr     (chr)
  );

  rx_buffer u_buf (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .chr         (chr),
    .rd_strobe   (rd_strobe),
    .err_clr     (err_clr),
    .rx_data     (rx_data),
    .buf_full    (buf_full),
    .err_overrun (err_overrun),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .rx_irq      (rx_irq)
  );
endmodule

// File: tb/uart_rx_dbuf_tb_top.sv
module uart_rx_dbuf_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        rxd;
  logic [15:0] baud_div;
  logic        fmt_len8, fmt_par_en, fmt_par_odd, fmt_stop2;
  logic        rd_strobe, err_clr;
  logic [7:0]  rx_data;
  logic        buf_full, err_overrun, err_parity, err_frame, rx_irq;

  int nchk  = 0;
  int nfail = 0;
  int irq_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_rx_dbuf dut_i (
    .clk(clk), .rst(rst), .rxd_in(rxd), .baud_div(baud_div),
    .fmt_len8(fmt_len8), .fmt_par_en(fmt_par_en), .fmt_par_odd(fmt_par_odd),
    .fmt_stop2(fmt_stop2), .rd_strobe(rd_strobe), .err_clr(err_clr),
    .rx_data(rx_data), .buf_full(buf_full), .err_overrun(err_overrun),
    .err_parity(err_parity), .err_frame(err_frame), .rx_irq(rx_irq)
  );

  always @(posedge clk) if (!rst && rx_irq) irq_cnt++;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bclk();
    return 16 * (int'(baud_div) + 1);
  endfunction

  task automatic drive(input logic b, input int n);
    rxd = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  // mode 0: plain, 1: probe flags inside stop bit 1, 2: read buffer during data bit 3
  task automatic send_frame(input logic [7:0] d, input bit par_bad, input bit stop_bad,
                            input int mode, input logic [7:0] prev);
    int nb, bc;
    logic [7:0] dm;
    logic p;
    nb = fmt_len8 ? 8 : 7;
    bc = bclk();
    dm = fmt_len8 ? d : {1'b0, d[6:0]};
    p  = (^dm) ^ fmt_par_odd ^ par_bad;
    drive(1'b0, bc);
    for (int i = 0; i < nb; i++) begin
      if (mode == 2 && i == 3) begin
        drive(d[i], bc / 4);
        chk("R11", "old char held during next frame", rx_data, prev);
        rxd = d[i];
        pulse_read();
        drive(d[i], bc - bc / 4 - 1);
      end else begin
        drive(d[i], bc);
      end
    end
    if (fmt_par_en) drive(p, bc);
    if (mode == 1) begin
      drive(~stop_bad, 4);
      chk("R6", "buf_full early in stop1", buf_full, 1'b0);
      drive(~stop_bad, 24);
      chk("R6", "buf_full late in stop1", buf_full, 1'b1);
      chk("R6", "data late in stop1", rx_data, dm);
      drive(~stop_bad, bc - 28);
    end else begin
      drive(~stop_bad, bc);
    end
    if (fmt_stop2) drive(1'b1, bc);
    drive(1'b1, bc);
  endtask

  task automatic set_fmt(input bit l8, input bit pe, input bit po, input bit s2);
    fmt_len8 = l8; fmt_par_en = pe; fmt_par_odd = po; fmt_stop2 = s2;
  endtask

  task automatic t_reset();
    chk("R1", "buf_full", buf_full, 1'b0);
    chk("R1", "errors", {err_overrun, err_parity, err_frame}, 3'b000);
    chk("R1", "irq", rx_irq, 1'b0);
    chk("R1", "data", rx_data, 8'h00);
  endtask

  task automatic t_basic();
    int i0;
    baud_div = 16'd1;
    set_fmt(1, 0, 0, 0);
    i0 = irq_cnt;
    send_frame(8'hA5, 0, 0, 0, 8'h00);
    chk("R3", "8-bit data", rx_data, 8'hA5);
    chk("R3", "buf_full", buf_full, 1'b1);
    chk("R7", "one irq", irq_cnt - i0, 1);
    chk("R4", "no errors", {err_overrun, err_parity, err_frame}, 3'b000);
    pulse_read();
    chk("R8", "empty after read", buf_full, 1'b0);
    chk("R8", "data kept after read", rx_data, 8'hA5);
  endtask

  task automatic t_seven();
    set_fmt(0, 0, 0, 0);
    send_frame(8'hD3, 0, 0, 0, 8'h00);
    chk("R3", "7-bit data top bit zero", rx_data, 8'h53);
    pulse_read();
  endtask

  task automatic t_parity();
    set_fmt(1, 1, 0, 0);
    send_frame(8'h3C, 0, 0, 0, 8'h00);
    chk("R4", "even good", err_parity, 1'b0);
    pulse_read();
    send_frame(8'h3D, 1, 0, 0, 8'h00);
    chk("R4", "even bad", err_parity, 1'b1);
    chk("R4", "data with bad parity", rx_data, 8'h3D);
    pulse_read();
    chk("R8", "read clears parity flag", err_parity, 1'b0);
    set_fmt(0, 1, 1, 1);
    send_frame(8'h15, 0, 0, 0, 8'h00);
    chk("R4", "odd good 7-bit", {err_parity, err_frame}, 2'b00);
    chk("R4", "odd data", rx_data, 8'h15);
    pulse_read();
    send_frame(8'h15, 1, 0, 0, 8'h00);
    chk("R4", "odd bad", err_parity, 1'b1);
    pulse_read();
  endtask

  task automatic t_frame();
    set_fmt(1, 0, 0, 0);
    send_frame(8'h7E, 0, 1, 0, 8'h00);
    chk("R5", "low stop sets frame error", err_frame, 1'b1);
    chk("R5", "buffer loaded", buf_full, 1'b1);
    pulse_read();
    chk("R8", "read clears frame flag", err_frame, 1'b0);
  endtask

  task automatic t_timing();
    int i0;
    set_fmt(1, 1, 1, 1);
    i0 = irq_cnt;
    send_frame(8'h81, 0, 0, 1, 8'h00);
    chk("R7", "irq for stop1 load", irq_cnt - i0, 1);
    pulse_read();
  endtask

  task automatic t_double();
    set_fmt(1, 0, 0, 0);
    send_frame(8'h11, 0, 0, 0, 8'h00);
    send_frame(8'h22, 0, 0, 2, 8'h11);
    chk("R11", "next char loaded", rx_data, 8'h22);
    chk("R11", "no overrun", err_overrun, 1'b0);
    chk("R11", "full", buf_full, 1'b1);
  endtask

  task automatic t_overrun();
    send_frame(8'h33, 0, 0, 0, 8'h00);
    chk("R9", "overrun set", err_overrun, 1'b1);
    chk("R9", "old data kept", rx_data, 8'h22);
    chk("R9", "still full", buf_full, 1'b1);
    pulse_clr();
    chk("R10", "clear drops overrun", err_overrun, 1'b0);
    chk("R10", "clear keeps full", buf_full, 1'b1);
    chk("R10", "clear keeps data", rx_data, 8'h22);
    pulse_read();
  endtask

  task automatic t_false_start();
    int i0;
    i0 = irq_cnt;
    drive(1'b0, 3 * (int'(baud_div) + 1));
    drive(1'b1, 2 * bclk());
    chk("R2", "glitch loads nothing", buf_full, 1'b0);
    chk("R2", "glitch no irq", irq_cnt - i0, 0);
    send_frame(8'h96, 0, 0, 0, 8'h00);
    chk("R2", "frame after glitch", rx_data, 8'h96);
    pulse_read();
  endtask

  task automatic t_baud();
    baud_div = 16'd4;
    set_fmt(1, 0, 0, 0);
    drive(1'b1, bclk());
    send_frame(8'hC3, 0, 0, 0, 8'h00);
    chk("R12", "data at div 4", rx_data, 8'hC3);
    pulse_read();
    baud_div = 16'd0;
    drive(1'b1, 16);
    send_frame(8'h4B, 0, 0, 0, 8'h00);
    chk("R12", "data at div 0", rx_data, 8'h4B);
    pulse_read();
  endtask

  initial begin
    rst = 1'b1; rxd = 1'b1; baud_div = 16'd1;
    rd_strobe = 1'b0; err_clr = 1'b0;
    set_fmt(1, 0, 0, 0);
    repeat (6) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    drive(1'b1, 64);
    t_basic();
    t_seven();
    t_parity();
    t_frame();
    t_timing();
    t_double();
    t_overrun();
    t_false_start();
    t_baud();
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule